// File: doc/BRIEF.md
# Sync frequency measurement unit

This block measures the period of the horizontal and vertical sync lines of a display input in cycles of a free-running reference clock. Each raw sync line first passes through a two-stage synchronizer. The rising edge of the synchronized level is taken as the active edge. A free-running counter per channel measures the spacing between consecutive active edges. At every edge the counter's value is copied into a period register that software can read.

A count that reaches all ones saturates, and the channel raises an overflow flag. The flag drops by itself at the first edge that closes a period short enough to fit. Each channel also has a presence timeout. A line with no active edge for `PRES_TO` cycles is reported absent. While absent, the channel tracks the steady level of the idle line in an off-level flag, which software consults only when the matching presence flag is 0.

Software reads the results as bytes through a small combinational read port. Polarity correction and blanking generation are handled elsewhere.

Top module: `sync_period_meter`

## Requirements
- R1: `h_period` (14 bits) holds the number of reference clock cycles between the two most recent rising edges of `hsync_in`. It is updated three clock edges after the raw rising edge arrives. The first rising edge after reset only starts the count and does not update the register.
- R2: `v_period` (12 bits) behaves the same way for `vsync_in`.
- R3: A period of all ones (16383 horizontal, 4095 vertical) or longer is reported as all ones with the channel's overflow flag set. The flag also rises during the count as soon as the counter saturates.
- R4: The overflow flag clears without any software action at the first rising edge that closes a period shorter than all ones. That period's value is latched at the same time.
- R5: A presence flag goes to 1 with each latched rising edge. It goes to 0 once `PRES_TO` cycles pass with no further rising edge.
- R6: While a channel is absent, its off-level flag follows the synchronized input level (1 = idle high, 0 = idle low). While the channel is present, the flag holds its value.
- R7: The read port is combinational. It returns the following bytes:
  - address 0: `{h_ovf, 1'b0, h_period[13:8]}`
  - address 1: `h_period[7:0]`
  - address 2: `{v_ovf, 3'b0, v_period[11:8]}`
  - address 3: `v_period[7:0]`
  - address 4: `{4'b0, v_off_lvl, h_off_lvl, v_present, h_present}`
  - any other address: 0
- R8: While reset is asserted, every output and every readable byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hsync_in | input | 1 | Raw horizontal sync line |
| vsync_in | input | 1 | Raw vertical sync line |
| rd_addr | input | 3 | Read byte address |
| rd_data | output | 8 | Read byte |
| h_period | output | 14 | Latched horizontal period |
| v_period | output | 12 | Latched vertical period |
| h_ovf | output | 1 | Horizontal count saturated |
| v_ovf | output | 1 | Vertical count saturated |
| h_present | output | 1 | Horizontal sync detected |
| v_present | output | 1 | Vertical sync detected |
| h_off_lvl | output | 1 | Idle level of horizontal line, valid when absent |
| v_off_lvl | output | 1 | Idle level of vertical line, valid when absent |

## Verification
The bench drives periods of exactly all ones, one less than all ones, and longer than all ones. A design with an off-by-one in saturation would report the boundary period as in range, or would flag the one-below period. A short period after an overflow must clear the flag; a design with a sticky flag would leave it set. The bench also uses two-cycle periods, which expose a synchronizer or edge detector that swallows back-to-back pulses. It lets both lines go idle high and idle low past the timeout, which catches a presence timer that never expires or an off-level flag that samples the wrong line. The first edge after a long silence must latch a saturated period, so a counter that restarts at reset rather than at the edge gives the wrong value.

// File: rtl/spm_pkg.sv
package spm_pkg;
  // Read port byte addresses
  typedef enum logic [2:0] {
    RA_H_HI = 3'd0,
    RA_H_LO = 3'd1,
    RA_V_HI = 3'd2,
    RA_V_LO = 3'd3,
    RA_STAT = 3'd4
  } spm_addr_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/spm_rst_sync.sv
module spm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= 2'b00;
    else        pipe_q <= {pipe_q[0], 1'b1};
  end

  assign rst_n_s = pipe_q[1];
endmodule

// File: rtl/spm_sync2.sv
module spm_sync2 #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spm_period_chan.sv
module spm_period_chan #(
  parameter int CW = 14,
  parameter int TO = 65536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl,
  output logic [CW-1:0] period,
  output logic          ovf,
  output logic          present,
  output logic          off_lvl
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam int            TOW  = (TO > 2) ? $clog2(TO) : 1;
  localparam logic [TOW-1:0] TO_LAST = TOW'(TO - 1);

  logic            lvl_d_q;
  logic            armed_q, armed_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [CW-1:0]   per_q, per_n;
  logic            ovf_q, ovf_n;
  logic            pres_q, pres_n;
  logic [TOW-1:0]  to_q, to_n;
  logic            off_q;
  logic            rise, at_max, off_en;

  assign rise   = lvl & ~lvl_d_q;
  assign at_max = (cnt_q == CMAX);
  assign off_en = ~pres_q;

  always_comb begin
    cnt_n   = cnt_q;
    armed_n = armed_q | rise;
    per_n   = per_q;
    ovf_n   = ovf_q;
    pres_n  = pres_q;
    to_n    = to_q;
    if (rise) begin
      cnt_n = CW'(1);
      if (armed_q) begin
        per_n = cnt_q;
        ovf_n = at_max;
      end
    end else if (armed_q) begin
      if (at_max) ovf_n = 1'b1;
      else        cnt_n = cnt_q + CW'(1);
    end
    if (rise) begin
      pres_n = 1'b1;
      to_n   = '0;
    end else if (pres_q) begin
      if (to_q == TO_LAST) pres_n = 1'b0;
      else                 to_n   = to_q + TOW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d_q <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      per_q   <= '0;
      ovf_q   <= 1'b0;
      pres_q  <= 1'b0;
      to_q    <= '0;
    end else begin
      lvl_d_q <= lvl;
      armed_q <= armed_n;
      cnt_q   <= cnt_n;
      per_q   <= per_n;
      ovf_q   <= ovf_n;
      pres_q  <= pres_n;
      to_q    <= to_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= 1'b0;
    else if (off_en) off_q <= lvl;
  end

  assign period  = per_q;
  assign ovf     = ovf_q;
  assign present = pres_q;
  assign off_lvl = off_q;
endmodule

// File: rtl/spm_regmux.sv
module spm_regmux
  import spm_pkg::*;
#(
  parameter int HW = 14,
  parameter int VW = 12
) (
  input  logic [2:0]    rd_addr,
  input  logic [HW-1:0] h_period,
  input  logic [VW-1:0] v_period,
  input  logic          h_ovf,
  input  logic          v_ovf,
  input  logic [3:0]    status,
  output logic [7:0]    rd_data
);
  always_comb begin
    rd_data = 8'h00;
    case (rd_addr)
      RA_H_HI: rd_data = {h_ovf, 7'(h_period >> 8)};
      RA_H_LO: rd_data = h_period[7:0];
      RA_V_HI: rd_data = {v_ovf, 7'(v_period >> 8)};
      RA_V_LO: rd_data = v_period[7:0];
      RA_STAT: rd_data = {4'b0000, status};
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/sync_period_meter.sv
module sync_period_meter
  import spm_pkg::*;
#(
  parameter int HW      = 14,
  parameter int VW      = 12,
  parameter int PRES_TO = 65536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync_in,
  input  logic          vsync_in,
  input  logic [2:0]    rd_addr,
  output logic [7:0]    rd_data,
  output logic [HW-1:0] h_period,
  output logic [VW-1:0] v_period,
  output logic          h_ovf,
  output logic          v_ovf,
  output logic          h_present,
  output logic          v_present,
  output logic          h_off_lvl,
  output logic          v_off_lvl
);
  logic       rst_n_s;
  logic [1:0] lvl_s;

  spm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  spm_sync2 #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .d({vsync_in, hsync_in}), .q(lvl_s)
  );

  spm_period_chan #(.CW(HW), .TO(PRES_TO)) u_hchan (
    .clk(clk), .rst_n(rst_n_s), .lvl(lvl_s[0]),
    .period(h_period), .ovf(h_ovf), .present(h_present), .off_lvl(h_off_lvl)
  );

  spm_period_chan #(.CW(VW), .TO(PRES_TO)) u_vchan (
    .clk(clk), .rst_n(rst_n_s), .lvl(lvl_s[1]),
    .period(v_period), .ovf(v_ovf), .present(v_present), .off_lvl(v_off_lvl)
  );

  spm_regmux #(.HW(HW), .VW(VW)) u_mux (
    .rd_addr(rd_addr), .h_period(h_period), .v_period(v_period),
    .h_ovf(h_ovf), .v_ovf(v_ovf),
    .status({v_off_lvl, h_off_lvl, v_present, h_present}),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/sync_period_meter_chk.sv
module sync_period_meter_chk #(
  parameter int HW = 14,
  parameter int VW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    rd_addr,
  input logic [7:0]    rd_data,
  input logic [HW-1:0] h_period,
  input logic [VW-1:0] v_period,
  input logic          h_ovf,
  input logic          v_ovf,
  input logic          h_present,
  input logic          v_present,
  input logic          h_off_lvl,
  input logic          v_off_lvl
);
  localparam logic [HW-1:0] HMAX = {HW{1'b1}};
  localparam logic [VW-1:0] VMAX = {VW{1'b1}};

  // R3: a freshly latched period carries the flag exactly when it is saturated
  p_hovf_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(h_period) |-> (h_ovf == (h_period == HMAX)));
  p_vovf_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(v_period) |-> (v_ovf == (v_period == VMAX)));

  // R4: the flag only drops together with a new, in-range period
  p_hovf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(h_ovf) |-> (!$stable(h_period) && h_period != HMAX));
  p_vovf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(v_ovf) |-> (!$stable(v_period) && v_period != VMAX));

  // R6: off-level flags frozen while the sync is present
  p_hoff_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (h_present && $past(h_present)) |-> $stable(h_off_lvl));
  p_voff_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (v_present && $past(v_present)) |-> $stable(v_off_lvl));

  // R7: read port bytes agree with the channel outputs
  p_rd_hlo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd1) |-> (rd_data == h_period[7:0]));
  p_rd_vlo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd3) |-> (rd_data == v_period[7:0]));
  p_rd_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd4) |-> (rd_data == {4'b0000, v_off_lvl, h_off_lvl, v_present, h_present}));
endmodule

bind sync_period_meter sync_period_meter_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
  .h_period(h_period), .v_period(v_period), .h_ovf(h_ovf), .v_ovf(v_ovf),
  .h_present(h_present), .v_present(v_present),
  .h_off_lvl(h_off_lvl), .v_off_lvl(v_off_lvl)
);

// File: tb/sim_sync_period_meter.sv
`timescale 1ns/100ps
module sim_sync_period_meter;
  localparam int    HW   = 14;
  localparam int    VW   = 12;
  localparam int    TO   = 12000;
  localparam longint HMAX = (1 << HW) - 1;
  localparam longint VMAX = (1 << VW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hs, vs;
  logic [2:0]    rd_addr;
  logic [7:0]    rd_data;
  logic [HW-1:0] h_period;
  logic [VW-1:0] v_period;
  logic          h_ovf, v_ovf, h_present, v_present, h_off_lvl, v_off_lvl;

  always #2 clk = ~clk;

  sync_period_meter #(.HW(HW), .VW(VW), .PRES_TO(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .hsync_in(hs), .vsync_in(vs),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .h_period(h_period), .v_period(v_period), .h_ovf(h_ovf), .v_ovf(v_ovf),
    .h_present(h_present), .v_present(v_present),
    .h_off_lvl(h_off_lvl), .v_off_lvl(v_off_lvl)
  );

  typedef struct {
    bit     is_v;
    longint val;
    bit     ovf;
    longint due;
  } exp_t;

  exp_t   sb[$];
  longint cyc = 0;
  longint h_last = -1, v_last = -1;
  int     checks = 0, fails = 0;
  bit     prev_h_ovf = 0, prev_v_ovf = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Driver side: raise a line at the current negedge and push the expected period
  task automatic h_rise();
    longint d;
    hs = 1'b1;
    if (h_last >= 0) begin
      d = cyc - h_last;
      sb.push_back('{0, (d > HMAX) ? HMAX : d, d >= HMAX, cyc + 3});
    end
    h_last = cyc;
  endtask

  task automatic v_rise();
    longint d;
    vs = 1'b1;
    if (v_last >= 0) begin
      d = cyc - v_last;
      sb.push_back('{1, (d > VMAX) ? VMAX : d, d >= VMAX, cyc + 3});
    end
    v_last = cyc;
  endtask

  task automatic h_wave(int n, int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk); h_rise();
      repeat (n / 2) @(negedge clk);
      hs = 1'b0;
      repeat (n - n / 2 - 1) @(negedge clk);
    end
  endtask

  task automatic v_wave(int n, int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk); v_rise();
      repeat (n / 2) @(negedge clk);
      vs = 1'b0;
      repeat (n - n / 2 - 1) @(negedge clk);
    end
  endtask

  task automatic read_chk(string req, logic [2:0] a, longint exp);
    rd_addr = a;
    #0.4;
    chk(req, $sformatf("read addr %0d", a), rd_data, exp);
  endtask

  // Monitor side: pop expected items when due and compare at the ports
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        if (e.due < cyc) chk("R1", "late scoreboard item", e.due, cyc);
        if (!e.is_v) begin
          chk("R1", "h_period", h_period, e.val);
          chk(e.ovf ? "R3" : (prev_h_ovf ? "R4" : "R3"), "h_ovf", h_ovf, e.ovf);
          read_chk("R7", 3'd0, (longint'(e.ovf) << 7) | (e.val >> 8));
          read_chk("R7", 3'd1, e.val & 255);
          prev_h_ovf = e.ovf;
        end else begin
          chk("R2", "v_period", v_period, e.val);
          chk(e.ovf ? "R3" : (prev_v_ovf ? "R4" : "R3"), "v_ovf", v_ovf, e.ovf);
          read_chk("R7", 3'd2, (longint'(e.ovf) << 7) | (e.val >> 8));
          read_chk("R7", 3'd3, e.val & 255);
          prev_v_ovf = e.ovf;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk("R1", "watchdog expired", 1, 0);
    finish_run();
  end

  task automatic wait_until(longint c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic status_chk(string req, bit hp, bit vp, bit ho, bit vo);
    chk(req, "h_present", h_present, hp);
    chk(req, "v_present", v_present, vp);
    chk("R6", "h_off_lvl", h_off_lvl, ho);
    chk("R6", "v_off_lvl", v_off_lvl, vo);
    read_chk("R7", 3'd4, {vo, ho, vp, hp});
  endtask

  initial begin
    longint t0;
    rst_n = 1'b0; hs = 1'b0; vs = 1'b0; rd_addr = 3'd0;
    repeat (5) @(negedge clk);
    // R8: reset state
    chk("R8", "h_period", h_period, 0);
    chk("R8", "v_period", v_period, 0);
    chk("R8", "ovf flags", {h_ovf, v_ovf}, 0);
    chk("R8", "presence", {h_present, v_present}, 0);
    chk("R8", "off levels", {h_off_lvl, v_off_lvl}, 0);
    for (int a = 0; a < 8; a++) read_chk("R8", 3'(a), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1/R2/R3/R4: period patterns on both lines at once
    fork
      begin
        h_wave(100, 3); h_wave(3, 4); h_wave(2, 3); h_wave(37, 2); h_wave(250, 2);
        h_wave(16383, 2); h_wave(16500, 1); h_wave(500, 2);
      end
      begin
        v_wave(50, 3); v_wave(2, 3); v_wave(4095, 2); v_wave(4094, 2);
        v_wave(4200, 2); v_wave(60, 2);
      end
    join
    repeat (10) @(negedge clk);
    chk("R1", "scoreboard drained", sb.size(), 0);

    // R5: presence holds just before the timeout and drops after it (lines idle low)
    t0 = (h_last > v_last) ? h_last : v_last;
    wait_until(h_last + TO - 10);
    chk("R5", "h_present before timeout", h_present, 1);
    wait_until(t0 + TO + 20);
    status_chk("R5", 0, 0, 0, 0);

    // R3 after silence, then R6 idle-high off level
    @(negedge clk);
    h_rise(); v_rise();
    t0 = cyc;
    wait_until(t0 + 6);
    chk("R5", "h_present after edge", h_present, 1);
    chk("R5", "v_present after edge", v_present, 1);
    wait_until(t0 + TO + 20);
    status_chk("R5", 0, 0, 1, 1);

    // R6: off level follows the line back to low while absent
    hs = 1'b0;
    wait_until(cyc + 3);
    chk("R6", "h_off_lvl follows low", h_off_lvl, 0);
    chk("R6", "v_off_lvl stays high", v_off_lvl, 1);
    vs = 1'b0;
    wait_until(cyc + 3);
    status_chk("R6", 0, 0, 0, 0);
    chk("R1", "scoreboard drained at end", sb.size(), 0);
    finish_run();
  end
endmodule